// File: doc/BRIEF.md
# Programmable Asymmetric Clock Prescaler

This block divides the system clock down to a slower conversion clock whose high and low phases are set separately. A five-bit high-phase setting and a three-bit low-phase setting give a high time of one to thirty-two system cycles and a low time of one to eight. Both phases are timed by one shared five-bit down counter.

At the start of every high phase the counter is loaded with the high setting. It then counts down once per system cycle. The high phase ends when the counter reaches zero. The counter keeps counting down past zero and wraps to all ones, so its three low bits fall from seven. The low phase ends when those three bits equal the bitwise inverse of the low setting.

Each edge of the divided clock comes with a one-cycle strobe, so downstream logic can act on an edge without its own edge detector. An enable input stops the divider and holds its output low. A legacy select input is kept only so that older configuration images stay valid, and it has no effect.

Top module: `clkdiv_asym`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `div_clk`, `rise_stb` and `fall_stb` are all 0 after that edge.
- R2: Each high phase lasts exactly `hi_cnt`+1 system cycles, for any `hi_cnt` from 0 to 31. The counter holds the loaded `hi_cnt` value in the first high cycle.
- R3: Each low phase lasts exactly `lo_cnt`+1 system cycles, for any `lo_cnt` from 0 to 7.
- R4: After reset, or after a stretch with `en` low, the first rising edge at which `en` is 1 starts a high phase. `div_clk` is 1 in the very next cycle.
- R5: `rise_stb` is 1 for exactly the first cycle of each high phase, and `fall_stb` is 1 for exactly the first cycle of each low phase. The two strobes are never 1 together.
- R6: `hi_cnt` is sampled only at the edge that starts a high phase, and `lo_cnt` only at the edge that starts a low phase. A change to either setting part-way through a phase leaves that phase's length unchanged.
- R7: `legacy_sel` has no effect on `div_clk`, `rise_stb` or `fall_stb`, whether it is held at 0, held at 1 or toggled.
- R8: At each rising edge with `en` at 0, the outputs become `div_clk`=0 with no strobe, even if this cuts a high phase short (no `fall_stb` is given then). When `en` returns to 1, a fresh high phase begins with a new load of `hi_cnt`.
- R9: With `hi_cnt`=11 and `lo_cnt`=7 the period is 20 cycles (12 high, 8 low). With `hi_cnt`=7 and `lo_cnt`=7 it is 16 cycles at 50% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, the output is held low |
| hi_cnt | input | 5 | High-phase setting; high time is this value plus one |
| lo_cnt | input | 3 | Low-phase setting; low time is this value plus one |
| legacy_sel | input | 1 | Compatibility select bit, accepted and ignored |
| div_clk | output | 1 | Divided clock level |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle |

## Verification
The cycle-by-cycle rules are checked on every cycle:
- a high phase continues until the counter reaches zero and then falls with a strobe;
- a low phase continues until the inverse compare matches and then rises with a strobe;
- the counter holds the freshly loaded high setting in the first high cycle;
- the strobes are exclusive and line up with the level;
- a low enable silences the output.

Only the bench scenarios can show whole-phase results:
- the measured phase lengths across the range of settings, including the extremes of 0 and 31;
- the two worked examples;
- that a setting written part-way through a phase leaves that phase's length alone;
- that toggling the legacy bit leaves the waveform unchanged.

// File: rtl/clkdiv_asym_pkg.sv
package clkdiv_asym_pkg;

  // Phase of the divided clock held by the sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Number of system cycles a phase lasts for a given setting
  function automatic int unsigned phase_cycles(input int unsigned setting);
    return setting + 1;
  endfunction

  // Full divided period for a pair of settings
  function automatic int unsigned period_cycles(input int unsigned hi_set,
                                                input int unsigned lo_set);
    return phase_cycles(hi_set) + phase_cycles(lo_set);
  endfunction

endpackage

// File: rtl/clkdiv_down_ctr.sv
module clkdiv_down_ctr #(
  parameter int HI_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            dec,
  input  logic [HI_W-1:0] load_val,
  output logic [HI_W-1:0] cnt_q
);

  localparam logic [HI_W-1:0] ONE = HI_W'(1);

  // Load wins over decrement. Decrement wraps from zero to all ones,
  // which gives the low phase its starting value.
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

endmodule

// File: rtl/clkdiv_phase_detect.sv
module clkdiv_phase_detect #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic [HI_W-1:0] cnt,
  input  logic [LO_W-1:0] lo_ref,
  output logic            hi_done,
  output logic            lo_done
);

  // The high phase ends in the cycle the counter reads zero
  assign hi_done = (cnt == '0);

  // The low phase ends when the low bits equal the inverted low setting
  assign lo_done = (cnt[LO_W-1:0] == ~lo_ref);

endmodule

// File: rtl/clkdiv_phase_seq.sv
module clkdiv_phase_seq
  import clkdiv_asym_pkg::*;
#(
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            hi_done,
  input  logic            lo_done,
  input  logic [LO_W-1:0] lo_cnt,
  output logic            ctr_load,
  output logic            ctr_dec,
  output logic [LO_W-1:0] lo_ref,
  output logic            level_q,
  output logic            run_q,
  output logic            rise_q,
  output logic            fall_q
);

  phase_e phase_q;
  logic   start_hi;
  logic   end_hi;

  // A high phase starts on the first enabled cycle, or when the low compare matches
  assign start_hi = en && ((phase_q == PH_IDLE) || ((phase_q == PH_LOW) && lo_done));
  assign end_hi   = en && (phase_q == PH_HIGH) && hi_done;
  assign ctr_load = start_hi;
  assign ctr_dec  = en && (phase_q != PH_IDLE) && !start_hi;
  assign run_q    = (phase_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      lo_ref  <= '0;
    end else if (!en) begin
      phase_q <= PH_IDLE;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= start_hi;
      fall_q <= end_hi;
      if (start_hi) begin
        phase_q <= PH_HIGH;
        level_q <= 1'b1;
      end else if (end_hi) begin
        phase_q <= PH_LOW;
        level_q <= 1'b0;
        lo_ref  <= lo_cnt;
      end
    end
  end

endmodule

// File: rtl/clkdiv_asym.sv
module clkdiv_asym #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [HI_W-1:0] hi_cnt,
  input  logic [LO_W-1:0] lo_cnt,
  input  logic            legacy_sel,
  output logic            div_clk,
  output logic            rise_stb,
  output logic            fall_stb
);

  logic [HI_W-1:0] cnt_q;
  logic [LO_W-1:0] lo_ref;
  logic            hi_done;
  logic            lo_done;
  logic            ctr_load;
  logic            ctr_dec;
  logic            run_q;
  logic            unused_legacy;

  // Compatibility bit: accepted, never used
  assign unused_legacy = legacy_sel;

  clkdiv_down_ctr #(.HI_W(HI_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .dec      (ctr_dec),
    .load_val (hi_cnt),
    .cnt_q    (cnt_q)
  );

  clkdiv_phase_detect #(.HI_W(HI_W), .LO_W(LO_W)) u_det (
    .cnt     (cnt_q),
    .lo_ref  (lo_ref),
    .hi_done (hi_done),
    .lo_done (lo_done)
  );

  clkdiv_phase_seq #(.LO_W(LO_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .hi_done  (hi_done),
    .lo_done  (lo_done),
    .lo_cnt   (lo_cnt),
    .ctr_load (ctr_load),
    .ctr_dec  (ctr_dec),
    .lo_ref   (lo_ref),
    .level_q  (div_clk),
    .run_q    (run_q),
    .rise_q   (rise_stb),
    .fall_q   (fall_stb)
  );

endmodule

// File: rtl/clkdiv_asym_chk.sv
module clkdiv_asym_chk #(
  parameter int HI_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [HI_W-1:0] hi_cnt,
  input logic            div_clk,
  input logic            rise_stb,
  input logic            fall_stb,
  input logic [HI_W-1:0] cnt_q,
  input logic            hi_done,
  input logic            lo_done,
  input logic            run_q
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!div_clk && !rise_stb && !fall_stb));

  a_r2_load_high: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (cnt_q == $past(hi_cnt)));

  a_r2_high_holds: assert property (@(posedge clk) disable iff (rst)
    (en && div_clk && !hi_done) |=> div_clk);

  a_r2_zero_ends_high: assert property (@(posedge clk) disable iff (rst)
    (en && div_clk && hi_done) |=> (!div_clk && fall_stb));

  a_r3_low_holds: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !div_clk && !lo_done) |=> (!div_clk && !rise_stb));

  a_r3_match_ends_low: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !div_clk && lo_done) |=> (div_clk && rise_stb));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_stb, fall_stb}));

  a_r5_rise_with_high: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> div_clk);

  a_r5_fall_after_high: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (!div_clk && $past(div_clk)));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!div_clk && !rise_stb && !fall_stb));

endmodule

bind clkdiv_asym clkdiv_asym_chk #(.HI_W(HI_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .hi_cnt   (hi_cnt),
  .div_clk  (div_clk),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb),
  .cnt_q    (cnt_q),
  .hi_done  (hi_done),
  .lo_done  (lo_done),
  .run_q    (run_q)
);

// File: tb/sim_clkdiv_asym.sv
module sim_clkdiv_asym;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [4:0] hi_cnt = '0;
  logic [2:0] lo_cnt = '0;
  logic       legacy_sel = 1'b0;
  logic       div_clk, rise_stb, fall_stb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  clkdiv_asym u0 (
    .clk(clk), .rst(rst), .en(en), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .legacy_sel(legacy_sel), .div_clk(div_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait (at negedges) for the first high cycle; returns 0 on timeout
  task automatic wait_rise(output bit found);
    found = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rise_stb) begin
        found = 1;
        break;
      end
    end
  endtask

  // Starting in a first high cycle: measure the high and low lengths
  // and the strobe alignment. Ends in the next first high cycle.
  task automatic measure(output int hcyc, output int lcyc, output bit strobes_ok);
    hcyc = 0;
    lcyc = 0;
    strobes_ok = 1;
    while (div_clk && hcyc < 100) begin
      if (fall_stb || (rise_stb != (hcyc == 0))) strobes_ok = 0;
      hcyc++;
      @(negedge clk);
    end
    while (!div_clk && lcyc < 100) begin
      if (rise_stb || (fall_stb != (lcyc == 0))) strobes_ok = 0;
      lcyc++;
      @(negedge clk);
    end
    if (!rise_stb) strobes_ok = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    en  = 0;
    @(negedge clk);
    @(negedge clk);
    check(!div_clk && !rise_stb && !fall_stb, "R1 reset outputs", {div_clk, rise_stb, fall_stb}, 0);
    rst = 0;
  endtask

  task automatic t_phase(input int h, input int l, input string tag);
    int hc, lc;
    bit sok, f;
    do_reset();
    hi_cnt = 5'(h);
    lo_cnt = 3'(l);
    en = 1;
    @(negedge clk);
    check(rise_stb && div_clk, "R4 first enabled cycle starts high", {div_clk, rise_stb}, 3);
    measure(hc, lc, sok);
    measure(hc, lc, sok);
    check(hc == h + 1, {tag, " R2 high length"}, hc, h + 1);
    check(lc == l + 1, {tag, " R3 low length"}, lc, l + 1);
    check(sok, {tag, " R5 strobe alignment"}, sok, 1);
    wait_rise(f);
  endtask

  task automatic t_examples();
    int hc, lc;
    bit sok;
    t_phase(11, 7, "R9a");
    measure(hc, lc, sok);
    check(hc + lc == 20, "R9 period 11/7", hc + lc, 20);
    t_phase(7, 7, "R9b");
    measure(hc, lc, sok);
    check(hc + lc == 16 && hc == lc, "R9 period 7/7 balanced", hc * 100 + lc, 808);
  endtask

  task automatic t_midphase();
    int hc, lc;
    bit sok, f;
    do_reset();
    hi_cnt = 5'd3;
    lo_cnt = 3'd2;
    en = 1;
    wait_rise(f);
    hi_cnt = 5'd9;   // written in the first high cycle
    hc = 0;
    while (div_clk && hc < 100) begin
      hc++;
      @(negedge clk);
    end
    check(hc == 4, "R6 high unaffected by mid-phase hi_cnt", hc, 4);
    check(fall_stb, "R5 fall strobe on first low cycle", fall_stb, 1);
    lo_cnt = 3'd5;   // written in the first low cycle
    lc = 0;
    while (!div_clk && lc < 100) begin
      lc++;
      @(negedge clk);
    end
    check(lc == 3, "R6 low unaffected by mid-phase lo_cnt", lc, 3);
    measure(hc, lc, sok);
    check(hc == 10 && lc == 6, "R6 new settings at next loads", hc * 100 + lc, 1006);
  endtask

  task automatic t_legacy();
    int hc, lc;
    bit sok, f;
    do_reset();
    hi_cnt = 5'd4;
    lo_cnt = 3'd3;
    legacy_sel = 1;
    en = 1;
    wait_rise(f);
    measure(hc, lc, sok);
    check(hc == 5 && lc == 4 && sok, "R7 legacy_sel held high", hc * 100 + lc, 504);
    hc = 0;
    lc = 0;
    sok = 1;
    while (div_clk && hc < 100) begin
      legacy_sel = ~legacy_sel;
      if (fall_stb) sok = 0;
      hc++;
      @(negedge clk);
    end
    while (!div_clk && lc < 100) begin
      legacy_sel = ~legacy_sel;
      lc++;
      @(negedge clk);
    end
    check(hc == 5 && lc == 4 && sok && rise_stb, "R7 legacy_sel toggling", hc * 100 + lc, 504);
    legacy_sel = 0;
  endtask

  task automatic t_disable();
    int hc, lc, quiet;
    bit sok, f;
    do_reset();
    hi_cnt = 5'd6;
    lo_cnt = 3'd1;
    en = 1;
    wait_rise(f);
    @(negedge clk);
    en = 0;          // cut the high phase short
    quiet = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!div_clk && !rise_stb && !fall_stb) quiet++;
    end
    check(quiet == 10, "R8 output low without strobes while disabled", quiet, 10);
    en = 1;
    @(negedge clk);
    check(div_clk && rise_stb, "R4 resume starts high at once", {div_clk, rise_stb}, 3);
    measure(hc, lc, sok);
    check(hc == 7 && lc == 2 && sok, "R8 fresh load after re-enable", hc * 100 + lc, 702);
    en = 0;
  endtask

  task automatic t_hold_idle();
    do_reset();
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(!div_clk && !rise_stb, "R8 idle after reset with en low", {div_clk, rise_stb}, 0);
  endtask

  initial begin
    t_hold_idle();
    t_phase(0, 0, "min");
    t_phase(31, 7, "max");
    t_phase(2, 5, "mixed");
    t_phase(19, 0, "longhigh");
    t_examples();
    t_midphase();
    t_legacy();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule